// File: doc/BRIEF.md
# USB IN Endpoint Control and Status

This block holds the control and status state of a single USB device IN endpoint whose packets carry at most eight bytes. For every IN token the serial engine presents, it picks the handshake class the engine should send: a data packet, NAK or STALL. It also raises an interrupt request for completed packets and sent stalls, and produces a flush pulse toward the transmit FIFO.

Software reaches the endpoint through a simple register port with two locations. Location 0 is the control/status word and location 1 holds the interrupt mask. Status bits are cleared by writing 1. Request bits are set by writing 1, and writing 0 to any bit leaves it unchanged. The serial engine reports events as single-cycle strobes:

- IN token
- FIFO underrun
- packet sent and acknowledged
- host protocol violation
- CLEAR_FEATURE

It also drives a level input that marks a transfer in progress, and it supplies the FIFO byte count. When a hardware set event and a software clear of the same bit fall in one cycle, the set wins. All outputs are plain control or status pins. There is no stream interface, so no back-pressure applies.

Control/status word layout (location 0): bit 0 packet-done, bit 1 flush request, bit 2 underrun, bit 3 sent-stall, bit 4 force-stall, bit 5 stalled, bit 6 reserved, bit 7 short-packet.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, location 0 reads 0x00, location 1 reads 0x01, and `irq`, `hs_valid` and `fifo_flush` are 0.
- R2: An IN token yields `hs_valid`=1 for exactly the next cycle, with `hs_sel` encoded as 1=DATA, 2=NAK, 3=STALL. The priority is STALL first, then NAK, then DATA. NAK is chosen when the underrun bit is set, or when the FIFO count is 0 and the short-packet bit is clear. Otherwise DATA is chosen.
- R3: An underrun strobe sets bit 2, and tokens are answered with NAK while it is set. Writing 1 to bit 2 clears it. Bit 2 never raises `irq`.
- R4: Writing 1 to bit 4 sets force-stall. While force-stall is set, every IN token is answered with STALL.
- R5: While force-stall is set and `xfer_busy` is 0, the next clock edge clears bit 4 and sets bits 3 (sent-stall) and 5 (stalled). While `xfer_busy` is 1, bit 4 stays set and bit 3 stays clear.
- R6: A protocol-violation strobe sets bit 5 so that tokens get STALL, and it does not set bit 3.
- R7: A CLEAR_FEATURE strobe clears bit 5. After that, tokens are answered normally even while bit 3 is still 1. Writing 1 to bit 3 clears it.
- R8: Writing 1 to bit 7 sets short-packet, which lets an empty FIFO be answered with DATA. A sent strobe clears bit 7 and sets bit 0. Writing 1 to bit 0 clears bit 0. If bit 7 is written while the FIFO count equals the maximum packet size, the bit stays clear and `short_err` pulses for one cycle.
- R9: Writing 1 to bit 1 makes `fifo_flush` high for exactly the cycle after the write. Bit 1 always reads 0.
- R10: Bit 6 reads 0 at both locations, whatever was written.
- R11: Bit 0 of location 1 is the interrupt mask. `irq` = (mask is 0) and (bit 0 or bit 3 is set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register location: 0 = control/status, 1 = mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed location (combinational) |
| in_token | input | 1 | IN token strobe |
| fifo_underrun | input | 1 | Transmit FIFO underrun strobe |
| tx_done | input | 1 | Packet sent and acknowledged strobe |
| proto_violation | input | 1 | Host protocol violation strobe |
| clear_feature | input | 1 | CLEAR_FEATURE (endpoint halt) strobe |
| xfer_busy | input | 1 | Transfer in progress; delays stall entry |
| fifo_count | input | 4 | Bytes currently held in the transmit FIFO |
| hs_valid | output | 1 | Handshake decision valid, one cycle after a token |
| hs_sel | output | 2 | Handshake class: 1 DATA, 2 NAK, 3 STALL |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| short_err | output | 1 | Pulse: short-packet request refused on a full FIFO |
| irq | output | 1 | Interrupt request |

## Verification
Tokens are presented against four contrasting states: a filled FIFO, an empty FIFO, an empty FIFO with the short-packet flag, and a filled FIFO with a pending underrun. Together these separate the empty-FIFO NAK from the underrun NAK, and both from the zero-length DATA case. Stalls are provoked in two ways, by software force and by protocol violation, and the state of the sent-stall bit tells the two apart. A force issued while a transfer is busy shows whether stall entry is held off. Tokens sent after CLEAR_FEATURE while sent-stall is still set show that a stale status bit does not keep the endpoint stalled.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_DATA  = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  // control/status word bit positions
  localparam int B_DONE    = 0;
  localparam int B_FLUSH   = 1;
  localparam int B_UNDER   = 2;
  localparam int B_SENT    = 3;
  localparam int B_FORCE   = 4;
  localparam int B_STALLED = 5;
  localparam int B_RSVD    = 6;
  localparam int B_SHORT   = 7;

  localparam int B_MASK    = 0;

endpackage

// File: rtl/usb_in_ep_regs.sv
module usb_in_ep_regs
  import usb_in_ep_pkg::*;
#(
  parameter int MAX_PKT = 8,
  parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_w1c,
  input  logic             under_w1c,
  input  logic             short_w1s,
  input  logic             flush_w1,
  input  logic             mask_wr,
  input  logic             mask_val,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_underrun,
  input  logic             tx_done,
  output logic             done_q,
  output logic             under_q,
  output logic             short_q,
  output logic             mask_q,
  output logic             flush_o,
  output logic             short_err_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_PKT);

  logic short_bad;
  logic short_ok;

  assign short_bad = short_w1s && (fifo_count == FULL_CNT);
  assign short_ok  = short_w1s && !short_bad;

  // status bits: hardware set wins over software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (tx_done)        done_q <= 1'b1;
      else if (done_w1c)  done_q <= 1'b0;
      if (fifo_underrun)  under_q <= 1'b1;
      else if (under_w1c) under_q <= 1'b0;
    end
  end

  // short-packet flag: software sets, packet completion consumes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        short_q <= 1'b0;
    else if (short_ok) short_q <= 1'b1;
    else if (tx_done)  short_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_o     <= 1'b0;
      short_err_o <= 1'b0;
      mask_q      <= 1'b1;
    end else begin
      flush_o     <= flush_w1;
      short_err_o <= short_bad;
      if (mask_wr) mask_q <= mask_val;
    end
  end

endmodule

// File: rtl/usb_in_ep_stall.sv
module usb_in_ep_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic force_w1s,
  input  logic sent_w1c,
  input  logic xfer_busy,
  input  logic proto_violation,
  input  logic clear_feature,
  output logic fst_q,
  output logic sst_q,
  output logic forced_q,
  output logic auto_q,
  output logic stall_any
);

  logic enter;

  // a pending force request enters the stall state once the endpoint is idle
  assign enter     = fst_q && !xfer_busy;
  assign stall_any = fst_q || forced_q || auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fst_q <= 1'b0;
    else if (enter)     fst_q <= 1'b0;
    else if (force_w1s) fst_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sst_q <= 1'b0;
    else if (enter)    sst_q <= 1'b1;
    else if (sent_w1c) sst_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      forced_q <= 1'b0;
      auto_q   <= 1'b0;
    end else begin
      if (enter)              forced_q <= 1'b1;
      else if (clear_feature) forced_q <= 1'b0;
      if (proto_violation)    auto_q <= 1'b1;
      else if (clear_feature) auto_q <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_in_ep_hs.sv
module usb_in_ep_hs
  import usb_in_ep_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_token,
  input  logic             stall_any,
  input  logic             under_q,
  input  logic             short_q,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             hs_valid,
  output hs_e              hs_sel
);

  hs_e decide;

  always_comb begin
    if (stall_any)
      decide = HS_STALL;
    else if (under_q || ((fifo_count == '0) && !short_q))
      decide = HS_NAK;
    else
      decide = HS_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_sel   <= HS_NONE;
    end else begin
      hs_valid <= in_token;
      hs_sel   <= in_token ? decide : HS_NONE;
    end
  end

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 8,
  parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_token,
  input  logic              fifo_underrun,
  input  logic              tx_done,
  input  logic              proto_violation,
  input  logic              clear_feature,
  input  logic              xfer_busy,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              hs_valid,
  output logic [1:0]        hs_sel,
  output logic              fifo_flush,
  output logic              short_err,
  output logic              irq
);

  logic wr_csr, wr_msk;
  logic done_q, under_q, short_q, mask_q;
  logic fst_q, sst_q, forced_q, auto_q, stall_any;
  hs_e  hs_sel_e;
  logic unused_wbits;

  assign wr_csr = reg_wr && !reg_addr;
  assign wr_msk = reg_wr &&  reg_addr;
  assign unused_wbits = ^{reg_wdata[B_STALLED], reg_wdata[B_RSVD]};

  usb_in_ep_regs #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_w1c     (wr_csr && reg_wdata[B_DONE]),
    .under_w1c    (wr_csr && reg_wdata[B_UNDER]),
    .short_w1s    (wr_csr && reg_wdata[B_SHORT]),
    .flush_w1     (wr_csr && reg_wdata[B_FLUSH]),
    .mask_wr      (wr_msk),
    .mask_val     (reg_wdata[B_MASK]),
    .fifo_count   (fifo_count),
    .fifo_underrun(fifo_underrun),
    .tx_done      (tx_done),
    .done_q       (done_q),
    .under_q      (under_q),
    .short_q      (short_q),
    .mask_q       (mask_q),
    .flush_o      (fifo_flush),
    .short_err_o  (short_err)
  );

  usb_in_ep_stall u_stall (
    .clk            (clk),
    .rst_n          (rst_n),
    .force_w1s      (wr_csr && reg_wdata[B_FORCE]),
    .sent_w1c       (wr_csr && reg_wdata[B_SENT]),
    .xfer_busy      (xfer_busy),
    .proto_violation(proto_violation),
    .clear_feature  (clear_feature),
    .fst_q          (fst_q),
    .sst_q          (sst_q),
    .forced_q       (forced_q),
    .auto_q         (auto_q),
    .stall_any      (stall_any)
  );

  usb_in_ep_hs #(.CNT_W(CNT_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_token  (in_token),
    .stall_any (stall_any),
    .under_q   (under_q),
    .short_q   (short_q),
    .fifo_count(fifo_count),
    .hs_valid  (hs_valid),
    .hs_sel    (hs_sel_e)
  );

  assign hs_sel = hs_sel_e;
  assign irq    = !mask_q && (done_q || sst_q);

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[B_DONE]    = done_q;
      reg_rdata[B_UNDER]   = under_q;
      reg_rdata[B_SENT]    = sst_q;
      reg_rdata[B_FORCE]   = fst_q;
      reg_rdata[B_STALLED] = forced_q || auto_q;
      reg_rdata[B_SHORT]   = short_q;
    end else begin
      reg_rdata[B_MASK]    = mask_q;
    end
  end

endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_token,
  input logic       proto_violation,
  input logic       flush_wr,
  input logic       rsvd_bit,
  input logic       hs_valid,
  input logic [1:0] hs_sel,
  input logic       fifo_flush,
  input logic       irq,
  input logic       fst_q,
  input logic       sst_q,
  input logic       under_q,
  input logic       stall_any,
  input logic       mask_q,
  input logic       done_q
);

  AST_NO_TOKEN_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_token |=> !hs_valid); // R2

  AST_UNDER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && under_q && !stall_any) |=> (hs_valid && hs_sel == 2'd2)); // R3

  AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && stall_any) |=> (hs_valid && hs_sel == 2'd3)); // R4

  AST_SENT_CLEARS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sst_q) |-> !fst_q); // R5

  AST_PV_NO_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_violation && !fst_q && !sst_q) |=> !sst_q); // R6

  AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(flush_wr)); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsvd_bit); // R10

  AST_MASK_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq); // R11

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_q || sst_q)); // R11

endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_token       (in_token),
  .proto_violation(proto_violation),
  .flush_wr       (reg_wr && !reg_addr && reg_wdata[1]),
  .rsvd_bit       (reg_rdata[6]),
  .hs_valid       (hs_valid),
  .hs_sel         (hs_sel),
  .fifo_flush     (fifo_flush),
  .irq            (irq),
  .fst_q          (fst_q),
  .sst_q          (sst_q),
  .under_q        (under_q),
  .stall_any      (stall_any),
  .mask_q         (mask_q),
  .done_q         (done_q)
);

// File: tb/usb_in_ep_ctrl_tb.sv
`timescale 1ns/100ps
module usb_in_ep_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       in_token = 1'b0, fifo_underrun = 1'b0, tx_done = 1'b0;
  logic       proto_violation = 1'b0, clear_feature = 1'b0, xfer_busy = 1'b0;
  logic [3:0] fifo_count = '0;
  logic       hs_valid, fifo_flush, short_err, irq;
  logic [1:0] hs_sel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [1:0] DATA = 2'd1, NAK = 2'd2, STALL = 2'd3;

  always #2.5 clk = ~clk;

  usb_in_ep_ctrl u_dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic token(input string req, input logic [1:0] exp);
    @(negedge clk); in_token = 1'b1;
    @(negedge clk); in_token = 1'b0;
    check({req, " hs_valid"}, {7'd0, hs_valid}, 8'd1);
    check({req, " hs_sel"}, {6'd0, hs_sel}, {6'd0, exp});
    @(negedge clk);
    check({req, " hs_valid one cycle"}, {7'd0, hs_valid}, 8'd0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b0, d); check("R1 csr", d, 8'h00);
    rd(1'b1, d); check("R1 mask", d, 8'h01);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 hs_valid", {7'd0, hs_valid}, 8'd0);
    check("R1 flush", {7'd0, fifo_flush}, 8'd0);
  endtask

  task automatic t_data_nak;
    fifo_count = 4'd4; token("R2 filled fifo", DATA);
    fifo_count = 4'd0; token("R2 empty fifo", NAK);
    fifo_count = 4'd8; token("R2 full fifo", DATA);
  endtask

  task automatic t_short;
    logic [7:0] d;
    fifo_count = 4'd0;
    wr(1'b0, 8'h80);
    rd(1'b0, d); check("R8 short set", d, 8'h80);
    token("R8 zero-length", DATA);
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    rd(1'b0, d); check("R8 done consumes short", d, 8'h01);
    wr(1'b0, 8'h01);
    rd(1'b0, d); check("R8 done w1c", d, 8'h00);
    fifo_count = 4'd8;
    wr(1'b0, 8'h80);
    check("R8 short_err", {7'd0, short_err}, 8'd1);
    rd(1'b0, d); check("R8 short refused", d, 8'h00);
    @(negedge clk);
    check("R8 short_err pulse", {7'd0, short_err}, 8'd0);
  endtask

  task automatic t_under;
    logic [7:0] d;
    fifo_count = 4'd4;
    wr(1'b1, 8'h00);
    @(negedge clk); fifo_underrun = 1'b1; @(negedge clk); fifo_underrun = 1'b0;
    rd(1'b0, d); check("R3 underrun bit", d, 8'h04);
    token("R3 underrun nak", NAK);
    check("R3 no irq", {7'd0, irq}, 8'd0);
    wr(1'b0, 8'h04);
    rd(1'b0, d); check("R3 w1c", d, 8'h00);
    token("R3 data after clear", DATA);
    wr(1'b1, 8'h01);
  endtask

  task automatic t_force;
    logic [7:0] d;
    fifo_count = 4'd4;
    xfer_busy = 1'b1;
    wr(1'b0, 8'h10);
    rd(1'b0, d); check("R4 force set", d, 8'h10);
    token("R4 force stall", STALL);
    rd(1'b0, d); check("R5 held while busy", d, 8'h10);
    xfer_busy = 1'b0;
    @(negedge clk);
    rd(1'b0, d); check("R5 entry", d, 8'h28);
    token("R4 stalled", STALL);
    @(negedge clk); clear_feature = 1'b1; @(negedge clk); clear_feature = 1'b0;
    rd(1'b0, d); check("R7 clear_feature", d, 8'h08);
    token("R7 resumes with sst set", DATA);
    wr(1'b0, 8'h08);
    rd(1'b0, d); check("R7 sst w1c", d, 8'h00);
  endtask

  task automatic t_pv;
    logic [7:0] d;
    fifo_count = 4'd4;
    @(negedge clk); proto_violation = 1'b1; @(negedge clk); proto_violation = 1'b0;
    rd(1'b0, d); check("R6 auto stall no sst", d, 8'h20);
    token("R6 auto stall", STALL);
    @(negedge clk); clear_feature = 1'b1; @(negedge clk); clear_feature = 1'b0;
    rd(1'b0, d); check("R6 cleared", d, 8'h00);
    token("R6 resumes", DATA);
  endtask

  task automatic t_flush;
    logic [7:0] d;
    wr(1'b0, 8'h02);
    check("R9 flush pulse", {7'd0, fifo_flush}, 8'd1);
    rd(1'b0, d); check("R9 bit1 reads 0", d, 8'h00);
    @(negedge clk);
    check("R9 flush one cycle", {7'd0, fifo_flush}, 8'd0);
  endtask

  task automatic t_rsvd;
    logic [7:0] d;
    wr(1'b0, 8'h40);
    rd(1'b0, d); check("R10 csr bit6", d, 8'h00);
    wr(1'b1, 8'h41);
    rd(1'b1, d); check("R10 mask bit6", d, 8'h01);
  endtask

  task automatic t_irq;
    wr(1'b1, 8'h00);
    check("R11 unmasked idle", {7'd0, irq}, 8'd0);
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    check("R11 done irq", {7'd0, irq}, 8'd1);
    wr(1'b1, 8'h01);
    check("R11 masked", {7'd0, irq}, 8'd0);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h01);
    check("R11 done cleared", {7'd0, irq}, 8'd0);
    wr(1'b0, 8'h10);
    @(negedge clk);
    check("R11 sst irq", {7'd0, irq}, 8'd1);
    @(negedge clk); clear_feature = 1'b1; @(negedge clk); clear_feature = 1'b0;
    wr(1'b0, 8'h08);
    check("R11 sst cleared", {7'd0, irq}, 8'd0);
    wr(1'b1, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_nak();
    t_short();
    t_under();
    t_force();
    t_pv();
    t_flush();
    t_rsvd();
    t_irq();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule